// File: doc/BRIEF.md
# Fractional Timer Prescaler

This block feeds a 64-bit free-running system counter. Each cycle it takes one of two incoming tick pulses: a crystal-derived tick or an alternate-clock tick. It passes the chosen tick through a 32-bit fractional rate scaler. On each scaled tick the counter advances by one or by two. The block also brings the scaled tick out as a one-cycle strobe, together with the step that was applied, so that downstream compare logic can follow each update.

Software sets the tick source and the step size in a control register. The rate ratio lives in a separate prescaler register, read against a reference of 2^31: 0x80000000 means one counter step per selected tick, and smaller values give proportionally fewer steps. On every selected tick the scaler adds the ratio to an accumulator. When the sum reaches 2^31 it issues a step and keeps the remainder, so fractional ratios spread their steps evenly over time. Registers are written one word at a time. The counter is read as two 32-bit halves.

Top module: `frac_prescaler`

## Requirements
- R1: After reset the control register reads 0, the prescaler reads 0x80000000 and the counter is 0.
- R2: Control bit 8 picks the tick source: 0 takes `xtal_tick`, 1 takes `alt_tick`. Pulses on the source that is not selected change nothing.
- R3: Control bit 9 sets the step: 0 adds 1 per scaled tick, 1 adds 2. `cnt_step` reports the step applied with each strobe.
- R4: With the prescaler at 0x80000000, every selected tick produces one step. Any larger value behaves exactly like 0x80000000.
- R5: Below 0x80000000, each selected tick adds the ratio to an accumulator that starts at 0 after reset. A step is issued when the sum reaches 2^31, and 2^31 is then removed. For example, 0x20000000 steps on every 4th tick and 0x60000000 gives 3 steps in 4 ticks.
- R6: A prescaler value of 0 stops the counter whatever the tick inputs do.
- R7: A selected tick sampled at one rising edge raises `cnt_tick` for exactly the following cycle. The counter takes its new value at that same edge. With no tick, `cnt_tick` stays low and the counter holds.
- R8: Read port decode on `rd_addr`: 0 returns the control register, with only bits 8 and 9 able to read as 1. 1 returns the prescaler, 2 returns counter bits 31:0 and 3 returns counter bits 63:32.
- R9: A write with `wr_en` high stores `wr_data` to the control register when `wr_addr` is 0 and to the prescaler when it is 1. Writes to addresses 2 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xtal_tick | input | 1 | Crystal-derived tick pulse, one cycle wide |
| alt_tick | input | 1 | Alternate-clock tick pulse, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 prescaler) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address (0 control, 1 prescaler, 2 count low, 3 count high) |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| cnt_tick | output | 1 | Strobe, high in the cycle the counter has just advanced |
| cnt_step | output | 2 | Step applied with the current strobe (1 or 2) |
| count | output | 64 | Current counter value |

## Verification
If the accumulator remainder were wrong, it would not show at once. It would appear at the first later tick where the sum should or should not have crossed 2^31, which is at most 2^31/ratio selected ticks after the fault. For that reason the fractional checks count steps over a full period and also check the exact tick on which the step lands. A wrong source select, step size or stop condition shows in the strobe and the counter on the first selected tick, one cycle after that tick.

// File: rtl/frac_prescaler_pkg.sv
// Package: shared register map and constants for the fractional prescaler.
package frac_prescaler_pkg;
    localparam int REG_W     = 32;
    localparam int CNT_W     = 64;
    localparam int SRC_BIT   = 8;   // control: tick source select
    localparam int STEP_BIT  = 9;   // control: step of one or two
    localparam logic [REG_W-1:0] UNITY_RATIO = 32'h8000_0000;

    typedef enum logic [1:0] {
        ADDR_CTRL   = 2'd0,
        ADDR_RATIO  = 2'd1,
        ADDR_CNT_LO = 2'd2,
        ADDR_CNT_HI = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/frac_accum.sv
// Fractional rate scaler. On each tick, adds the ratio (capped at 2^(W-1))
// to a remainder. It reports a carry when the sum reaches 2^(W-1) and keeps
// only the part below that. Assumes the tick is at most one pulse per cycle.
// The carry is combinational so that the counter can update at the same edge.
module frac_accum #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] ratio,
    output logic         carry
);
    localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] rem_q;
    logic [W-1:0] eff_ratio;
    logic [W-1:0] sum;

    // Cap the ratio at unity, then form the next sum.
    always_comb begin
        eff_ratio = (ratio > HALF) ? HALF : ratio;
        sum       = rem_q + eff_ratio;
        carry     = tick && sum[W-1];
    end

    // Keep the remainder below 2^(W-1) after each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rem_q <= '0;
        else if (tick)
            rem_q <= {1'b0, sum[W-2:0]};
    end
endmodule

// File: rtl/step_counter.sv
// Wide up-counter. It advances by one or two when told to. Assumes wrap at
// 2^W is acceptable.
module step_counter #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic         dbl,
    output logic [W-1:0] value
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] TWO = {{(W-2){1'b0}}, 2'b10};

    // Add the selected step on each advance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            value <= '0;
        else if (adv)
            value <= value + (dbl ? TWO : ONE);
    end
endmodule

// File: rtl/frac_prescaler.sv
// Top level: control and ratio registers, tick source select, fractional
// scaler, 64-bit counter and the read port. Assumes tick inputs are already
// synchronous to clk and one cycle wide.
module frac_prescaler
    import frac_prescaler_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xtal_tick,
    input  logic              alt_tick,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [1:0]        rd_addr,
    output logic [REG_W-1:0]  rd_data,
    output logic              cnt_tick,
    output logic [1:0]        cnt_step,
    output logic [CNT_W-1:0]  count
);
    localparam int HALVES = CNT_W / REG_W;

    logic             src_alt_q;
    logic             step_two_q;
    logic [REG_W-1:0] ratio_q;
    logic             sel_tick;
    logic             carry;
    logic [REG_W-1:0] cnt_word [HALVES];

    // Register writes; only the two control bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_alt_q  <= 1'b0;
            step_two_q <= 1'b0;
            ratio_q    <= UNITY_RATIO;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                ADDR_CTRL: begin
                    src_alt_q  <= wr_data[SRC_BIT];
                    step_two_q <= wr_data[STEP_BIT];
                end
                ADDR_RATIO: ratio_q <= wr_data;
                default: ;
            endcase
        end
    end

    // Pick the active tick source.
    always_comb sel_tick = src_alt_q ? alt_tick : xtal_tick;

    frac_accum #(.W(REG_W)) u_accum (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (sel_tick),
        .ratio (ratio_q),
        .carry (carry)
    );

    step_counter #(.W(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (carry),
        .dbl   (step_two_q),
        .value (count)
    );

    // Register the strobe and the applied step, aligned with the count update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_tick <= 1'b0;
            cnt_step <= 2'd0;
        end else begin
            cnt_tick <= carry;
            cnt_step <= carry ? (step_two_q ? 2'd2 : 2'd1) : 2'd0;
        end
    end

    // Split the counter into read words.
    for (genvar g = 0; g < HALVES; g++) begin : g_words
        assign cnt_word[g] = count[g*REG_W +: REG_W];
    end

    // Read mux.
    always_comb begin
        rd_data = '0;
        case (reg_addr_e'(rd_addr))
            ADDR_CTRL: begin
                rd_data[SRC_BIT]  = src_alt_q;
                rd_data[STEP_BIT] = step_two_q;
            end
            ADDR_RATIO:  rd_data = ratio_q;
            ADDR_CNT_LO: rd_data = cnt_word[0];
            ADDR_CNT_HI: rd_data = cnt_word[HALVES-1];
            default:     rd_data = '0;
        endcase
    end
endmodule

// File: rtl/frac_prescaler_chk.sv
// Checker for frac_prescaler, attached by bind. It watches the selected tick,
// the ratio register, the strobe and the counter.
module frac_prescaler_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sel_tick,
    input logic [31:0] ratio,
    input logic        cnt_tick,
    input logic [1:0]  cnt_step,
    input logic [63:0] count
);
    logic live_q;

    // Marks that at least one cycle out of reset has passed.
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    // R3
    step_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_tick |-> (cnt_step == 2'd1 || cnt_step == 2'd2));

    // R3
    count_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && cnt_tick) |-> (count == $past(count) + 64'(cnt_step)));

    // R7
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !cnt_tick) |-> (count == $past(count)));

    // R7
    no_tick_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !$past(sel_tick)) |-> !cnt_tick);

    // R6
    zero_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(ratio) == 32'd0) |-> !cnt_tick);

    // R4
    unity_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(sel_tick) && $past(ratio) >= 32'h8000_0000) |-> cnt_tick);
endmodule

bind frac_prescaler frac_prescaler_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_tick (sel_tick),
    .ratio    (ratio_q),
    .cnt_tick (cnt_tick),
    .cnt_step (cnt_step),
    .count    (count)
);

// File: tb/frac_prescaler_test.sv
module frac_prescaler_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xtal_tick = 1'b0;
    logic        alt_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = 2'd0;
    logic [31:0] rd_data;
    logic        cnt_tick;
    logic [1:0]  cnt_step;
    logic [63:0] count;

    int n_chk = 0;
    int n_bad = 0;
    longint unsigned exp_cnt = 0;

    frac_prescaler uut (
        .clk(clk), .rst_n(rst_n), .xtal_tick(xtal_tick), .alt_tick(alt_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .cnt_tick(cnt_tick), .cnt_step(cnt_step), .count(count)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_reg(input logic [1:0] a, output logic [31:0] d);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    // One-cycle pulses on the chosen input; returns the strobe count and the step sum.
    task automatic pulse(input bit use_alt, input int n, output int strobes, output int steps);
        strobes = 0; steps = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (use_alt) alt_tick = 1'b1; else xtal_tick = 1'b1;
            @(negedge clk);
            alt_tick = 1'b0; xtal_tick = 1'b0;
            strobes += int'(cnt_tick);
            if (cnt_tick) steps += int'(cnt_step);
        end
        @(negedge clk);
        check("R7 strobe drops", longint'(cnt_tick), 0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        read_reg(2'd0, d); check("R1 control", d, 0);
        read_reg(2'd1, d); check("R1 prescaler", d, 32'h8000_0000);
        check("R1 count", count, 0);
        check("R1 strobe", longint'(cnt_tick), 0);
    endtask

    task automatic t_unity_xtal();
        int s, st;
        pulse(1'b0, 5, s, st); exp_cnt += 5;
        check("R4 strobes per tick", s, 5);
        check("R3 step one", st, 5);
        check("R4 count", count, exp_cnt);
        pulse(1'b1, 4, s, st);
        check("R2 alt ignored", count, exp_cnt);
    endtask

    task automatic t_strobe_timing();
        @(negedge clk); xtal_tick = 1'b1;
        #1 check("R7 no early strobe", longint'(cnt_tick), 0);
        @(negedge clk); xtal_tick = 1'b0; exp_cnt += 1;
        check("R7 strobe next cycle", longint'(cnt_tick), 1);
        check("R7 count same edge", count, exp_cnt);
        @(negedge clk);
        check("R7 strobe one cycle", longint'(cnt_tick), 0);
    endtask

    task automatic t_alt_source();
        int s, st;
        write_reg(2'd0, 32'h0000_0100);
        pulse(1'b1, 3, s, st); exp_cnt += 3;
        check("R2 alt counts", count, exp_cnt);
        pulse(1'b0, 3, s, st);
        check("R2 xtal ignored", count, exp_cnt);
    endtask

    task automatic t_step_two();
        int s, st;
        write_reg(2'd0, 32'h0000_0200);
        pulse(1'b0, 3, s, st); exp_cnt += 6;
        check("R3 step two count", count, exp_cnt);
        check("R3 cnt_step sum", st, 6);
        write_reg(2'd0, 32'h0);
    endtask

    task automatic t_quarter();
        int s, st;
        write_reg(2'd1, 32'h2000_0000);
        pulse(1'b0, 3, s, st);
        check("R5 no step before 4th", s, 0);
        pulse(1'b0, 1, s, st); exp_cnt += 1;
        check("R5 step on 4th", s, 1);
        pulse(1'b0, 8, s, st); exp_cnt += 2;
        check("R5 quarter rate", count, exp_cnt);
    endtask

    task automatic t_three_quarter();
        int s, st;
        write_reg(2'd1, 32'h6000_0000);
        pulse(1'b0, 1, s, st);
        check("R5 first tick no step", s, 0);
        pulse(1'b0, 3, s, st); exp_cnt += 3;
        check("R5 three in four", s, 3);
        check("R5 count", count, exp_cnt);
    endtask

    task automatic t_stop();
        int s, st;
        write_reg(2'd1, 32'h0);
        pulse(1'b0, 6, s, st);
        check("R6 stopped strobes", s, 0);
        check("R6 stopped count", count, exp_cnt);
    endtask

    task automatic t_saturate();
        int s, st;
        write_reg(2'd1, 32'hFFFF_FFFF);
        pulse(1'b0, 4, s, st); exp_cnt += 4;
        check("R4 capped rate", s, 4);
        check("R4 capped count", count, exp_cnt);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        write_reg(2'd0, 32'hFFFF_FCFF);
        read_reg(2'd0, d); check("R8 ctrl other bits zero", d, 0);
        write_reg(2'd1, 32'h1234_5678);
        read_reg(2'd1, d); check("R9 prescaler write", d, 32'h1234_5678);
        write_reg(2'd2, 32'hDEAD_BEEF);
        write_reg(2'd3, 32'hCAFE_F00D);
        read_reg(2'd2, d); check("R9 count low untouched", d, exp_cnt & 64'hFFFF_FFFF);
        read_reg(2'd3, d); check("R8 count high", d, exp_cnt >> 32);
        read_reg(2'd1, d); check("R9 prescaler kept", d, 32'h1234_5678);
        write_reg(2'd0, 32'h0000_0300);
        read_reg(2'd0, d); check("R8 ctrl bits", d, 32'h300);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unity_xtal();
        t_strobe_timing();
        t_alt_source();
        t_step_two();
        t_quarter();
        t_three_quarter();
        t_stop();
        t_saturate();
        t_regs();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule